// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a watchdog counter that advances on a slow tick. The tick is a one-cycle enable in the system clock domain, produced by a low-speed oscillator. A 3-bit period code is captured while reset is held and stays fixed once reset is released. It selects one of eight overflow lengths, each one less than a power of two. Software keeps the system alive by writing a key byte to the restart register through a one-cycle write strobe. If the key does not arrive in time, the block raises a one-cycle reset request for the system reset controller. The block also raises the request at once when any other byte is written.

When the count reaches three quarters of the selected power of two, the block raises a one-cycle early-warning interrupt. Software can use it to service the watchdog before it bites. A mask input suppresses this interrupt. The counter keeps running after the warning and stops only on a key write or an overflow. Both outputs are registered, so each one appears on the clock edge after the event that causes it.

Top module: `early_warn_watchdog`

## Requirements
- R1: The period code maps 0 to 7 onto exponents 6, 7, 8, 9, 11, 13, 14 and 16. With no write, the reset request appears after tick number 2^N−1 counted from reset release.
- R2: The interrupt pulses after tick number 3·2^(N−2) of a period, which is 0.75·2^N, provided the mask is 0.
- R3: The count advances only on cycles where the tick is 1. Without ticks, no interrupt and no reset request are ever produced.
- R4: A write of 0xAC clears the count without raising the reset request. The next interrupt then comes after 3·2^(N−2) further ticks, and the next reset request after 2^N−1 further ticks.
- R5: A write of any byte other than 0xAC raises the reset request on the next cycle and clears the count.
- R6: The reset request is a one-cycle pulse and the count restarts from zero after it. The count keeps running after the interrupt, so an unserviced period still ends in a reset request.
- R7: While the mask is 1, the interrupt stays 0. Counting and the reset request are unaffected.
- R8: The interrupt is a one-cycle pulse and occurs at most once per period.
- R9: The period code is sampled while reset is low. Changing it after reset release has no effect until the next reset.
- R10: During and right after reset, the interrupt and the reset request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle low-speed count enable |
| periodSel | input | 3 | Period code, captured during reset |
| wrEn | input | 1 | One-cycle write strobe for the restart register |
| wrData | input | 8 | Byte written to the restart register |
| irqMask | input | 1 | 1 suppresses the early-warning interrupt |
| irq | output | 1 | Early-warning interrupt pulse |
| resetReq | output | 1 | Reset request pulse |

## Verification
The main function is run with all eight period codes under an unbroken tick stream. This separates an error in the exponent table from an error in the three-quarter threshold, because both tick positions are measured for every code. Directed sequences cover the remaining cases:
- A key write in mid-period shows a true restart from zero, as opposed to a missed or partial clear.
- A wrong byte shows an immediate reset request, as opposed to a silent restart.
- Masking, tick-free idle stretches, a period code changed after reset release, and two back-to-back periods show that the interrupt is suppressed, that counting needs ticks, that the period code is latched, and that the count restarts after overflow.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic clear;
    logic advance;
  } wdtStrobe_t;

  // Period code to exponent, non-uniform power-of-two steps
  function automatic logic [4:0] selExp(input logic [2:0] code);
    case (code)
      3'd0:    selExp = 5'd6;
      3'd1:    selExp = 5'd7;
      3'd2:    selExp = 5'd8;
      3'd3:    selExp = 5'd9;
      3'd4:    selExp = 5'd11;
      3'd5:    selExp = 5'd13;
      3'd6:    selExp = 5'd14;
      default: selExp = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] periodSel,
  input  wdtStrobe_t strobe,
  output logic       atWarnNext,
  output logic       atLimitNext
);

  localparam int EXT_W = CNT_W + 1;

  logic [2:0]       selReg;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] nextCount;
  logic [4:0]       expo;
  logic [EXT_W-1:0] limitExt;
  logic [EXT_W-1:0] warnExt;

  always_ff @(posedge clk) begin
    if (!rstN) selReg <= periodSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             count <= '0;
    else if (strobe.clear) count <= '0;
    else if (strobe.advance) count <= nextCount;
  end

  always_comb begin
    nextCount   = count + 1'b1;
    expo        = selExp(selReg);
    limitExt    = (EXT_W'(1) << expo) - EXT_W'(1);
    warnExt     = EXT_W'(3) << (expo - 5'd2);
    atWarnNext  = ({1'b0, nextCount} == warnExt);
    atLimitNext = ({1'b0, nextCount} == limitExt);
  end

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, count} < limitExt);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0));

  // R3
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.advance) |=> $stable(count));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(selReg));

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hAC
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       irqMask,
  input  logic       atWarnNext,
  input  logic       atLimitNext,
  output wdtStrobe_t strobe,
  output logic       irq,
  output logic       resetReq
);

  logic keyOk;
  logic badWr;
  logic stepOk;
  logic overflowNow;

  always_comb begin
    keyOk          = wrEn && (wrData == KEY);
    badWr          = wrEn && !keyOk;
    stepOk         = tick && !wrEn;
    overflowNow    = stepOk && atLimitNext;
    strobe.clear   = wrEn || overflowNow;
    strobe.advance = stepOk && !overflowNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq      <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      irq      <= stepOk && atWarnNext && !irqMask;
      resetReq <= badWr || overflowNow;
    end
  end

  // R5
  bad_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData != KEY) |=> resetReq);

  // R4
  key_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == KEY) |=> !resetReq);

  // R7
  mask_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |=> !irq);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> (!irq && !resetReq));

endmodule

// File: rtl/early_warn_watchdog.sv
module early_warn_watchdog
  import wdt_pkg::*;
#(
  parameter int         CNT_W = 16,
  parameter logic [7:0] KEY   = 8'hAC
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [2:0] periodSel,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       irqMask,
  output logic       irq,
  output logic       resetReq
);

  wdtStrobe_t strobe;
  logic       atWarnNext;
  logic       atLimitNext;

  wdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .periodSel   (periodSel),
    .strobe      (strobe),
    .atWarnNext  (atWarnNext),
    .atLimitNext (atLimitNext)
  );

  wdt_control #(.KEY(KEY)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .irqMask     (irqMask),
    .atWarnNext  (atWarnNext),
    .atLimitNext (atLimitNext),
    .strobe      (strobe),
    .irq         (irq),
    .resetReq    (resetReq)
  );

  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!irq && !resetReq));

endmodule

// File: tb/early_warn_watchdog_test.sv
`timescale 1ns/1ps
module early_warn_watchdog_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] periodSel = 3'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       irqMask = 1'b0;
  logic       irq;
  logic       resetReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  early_warn_watchdog uut (
    .clk(clk), .rstN(rstN), .tick(tick), .periodSel(periodSel),
    .wrEn(wrEn), .wrData(wrData), .irqMask(irqMask),
    .irq(irq), .resetReq(resetReq)
  );

  // Exponent per period code, indexed by code
  localparam int EXPS [8] = '{6, 7, 8, 9, 11, 13, 14, 16};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] code);
    @(negedge clk);
    rstN = 1'b0; tick = 1'b0; wrEn = 1'b0; periodSel = code;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Ticks every cycle until a reset request or maxT ticks
  task automatic runTicks(input int maxT, output int irqAt, output int rstAt,
                          output int irqCnt);
    irqAt = -1; rstAt = -1; irqCnt = 0;
    tick = 1'b1;
    for (int t = 1; t <= maxT; t++) begin
      @(negedge clk);
      if (irq) begin
        irqCnt++;
        if (irqAt < 0) irqAt = t;
      end
      if (resetReq) begin
        rstAt = t;
        break;
      end
    end
    tick = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    wrEn = 1'b1; wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    int ia, ra, ic, lim, warn;
    // R10: reset state
    doReset(3'd0);
    check("R10 irq after reset", int'(irq), 0);
    check("R10 resetReq after reset", int'(resetReq), 0);

    // Table walk over all period codes (R1, R2, R6, R8)
    for (int i = 0; i < 8; i++) begin
      lim  = (1 << EXPS[i]) - 1;
      warn = 3 << (EXPS[i] - 2);
      doReset(3'(i));
      runTicks(lim + 4, ia, ra, ic);
      check($sformatf("R1 reset tick code %0d", i), ra, lim);
      check($sformatf("R2 irq tick code %0d", i), ia, warn);
      check($sformatf("R8 irq count code %0d", i), ic, 1);
      @(negedge clk);
      check($sformatf("R6 pulse width code %0d", i), int'(resetReq), 0);
    end

    // R3: no ticks, nothing happens
    doReset(3'd0);
    ic = 0; ra = 0;
    repeat (200) begin
      @(negedge clk);
      if (irq) ic++;
      if (resetReq) ra++;
    end
    check("R3 no irq without tick", ic, 0);
    check("R3 no reset without tick", ra, 0);
    runTicks(100, ia, ra, ic);
    check("R3 count from zero after idle", ra, 63);

    // R4: key write mid-period restarts from zero
    doReset(3'd0);
    runTicks(40, ia, ra, ic);
    writeByte(8'hAC);
    check("R4 no reset on key", int'(resetReq), 0);
    runTicks(100, ia, ra, ic);
    check("R4 irq after key", ia, 48);
    check("R4 reset after key", ra, 63);

    // R5 / R6: wrong byte
    doReset(3'd0);
    runTicks(20, ia, ra, ic);
    writeByte(8'h55);
    check("R5 reset on bad byte", int'(resetReq), 1);
    @(negedge clk);
    check("R6 bad byte pulse width", int'(resetReq), 0);
    runTicks(100, ia, ra, ic);
    check("R6 restart after bad byte", ra, 63);

    // R7: mask
    doReset(3'd0);
    irqMask = 1'b1;
    runTicks(100, ia, ra, ic);
    check("R7 masked irq count", ic, 0);
    check("R7 reset still occurs", ra, 63);
    irqMask = 1'b0;

    // R6: back-to-back periods restart from zero
    doReset(3'd1);
    runTicks(200, ia, ra, ic);
    runTicks(200, ia, ra, ic);
    check("R6 second period reset", ra, 127);
    check("R6 second period irq", ia, 96);

    // R9: period code changed after release is ignored
    doReset(3'd0);
    @(negedge clk);
    periodSel = 3'd7;
    runTicks(200, ia, ra, ic);
    check("R9 latched period", ra, 63);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule